// File: doc/BRIEF.md
# Pushbutton Gesture and Tamper Controller

This block watches a single debounced pushbutton and a tamper switch. It turns what the user does with them into one-cycle request pulses. A single shared timing engine measures how long each press lasts and how long the button stays idle between presses. From those two measurements it recognises several gestures: a counted run of quick presses (one, three, or five or more), a hold past a first threshold, and a hold past a longer second threshold. All timing is counted in ticks of a 1 ms enable input, `tick_i`. Driving that input faster shortens every interval in proportion.

An 8-bit configuration word decides what each gesture does. The word is written through `cfg_we_i` and `cfg_wdata_i`. Depending on the word, a gesture can produce a system reset request, a user-space erase request, an alternate-boot reset request, a power-down request or an interrupt pulse. A long hold can put the block into a powered-down state. While in that state, the next momentary press only requests power-up. Debouncing, the erase itself, power sequencing and watchdog handling are left to neighbouring blocks.

Top module: `pb_gesture_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x81, the powered-down state is clear, and every request and interrupt output is low.
- R2: A press released before the first hold threshold counts as a quick press. A run of quick presses ends once the button has stayed idle for GAP_MS ticks. If the run held exactly one press, bit 0 decides the action: bit 0 = 1 gives one `rst_req_o` pulse, and bit 0 = 0 gives one `pb_irq_o` pulse.
- R3: A run of exactly three quick presses with bit 1 set gives one `erase_req_o` pulse and one `pb_irq_o` pulse.
- R4: A run of five or more quick presses with bit 3 set gives one `altboot_req_o` pulse, and no reset, erase or interrupt comes from that run. Runs of two or four presses, and runs of five or more with bit 3 clear, give nothing.
- R5: Holding the button for HOLD_MS ticks with bit 6 set gives one `pb_irq_o` pulse. With bit 6 clear, the hold gives nothing.
- R6: Holding the button for LONG_MS ticks with bit 2 set gives one `pwr_down_o` pulse and puts the block in the powered-down state.
- R7: In the powered-down state, the next quick press gives one `pwr_up_o` pulse and nothing else, and the state is left. No press is counted while the block is powered down.
- R8: A falling edge on `tamper_i` with bit 5 set gives one `erase_req_o` pulse and one `tamper_irq_o` pulse. With bit 5 clear, the same edge is ignored.
- R9: A press that reached the first hold threshold is not counted in a quick-press run when it is released.
- R10: A configuration write that changes bit 1 or bit 3 from 1 to 0 discards the run in progress, so the press count restarts from zero.
- R11: Bits 4 and 7 have no effect on any output.
- R12: Every request and interrupt output is high for one clock at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base enable, nominally every 1 ms |
| btn_i | input | 1 | Debounced pushbutton, 1 = pressed |
| tamper_i | input | 1 | Tamper switch, 1 = closed; a 1 to 0 edge is a release |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_o | output | 8 | Current configuration word |
| rst_req_o | output | 1 | System reset request pulse |
| erase_req_o | output | 1 | User-space erase request pulse |
| altboot_req_o | output | 1 | Alternate-boot reset request pulse |
| pwr_down_o | output | 1 | Power-down request pulse |
| pwr_up_o | output | 1 | Power-up request pulse |
| pb_irq_o | output | 1 | Pushbutton interrupt pulse |
| tamper_irq_o | output | 1 | Tamper interrupt pulse |

## Verification
The assertions assume that `btn_i` and `tamper_i` arrive already debounced and synchronous, and that `tick_i` is a single-cycle enable rather than a level. In the stimulus, the button and tamper inputs change only on the falling clock edge, and the tick toggles every cycle. Timing parameters are shortened for the bench. Randomised press runs keep every press and every inter-press gap well below the first threshold, so each run is counted as a clean quick-press sequence. Long holds, powered-down behaviour, tamper edges and aborting writes are covered by directed cases.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
  localparam int CFG_W = 8;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h81;
  localparam int B_SHORT_RST = 0;
  localparam int B_CLRKEY    = 1;
  localparam int B_PWRDN     = 2;
  localparam int B_ALTBOOT   = 3;
  localparam int B_TAMPER    = 5;
  localparam int B_HOLD      = 6;
  localparam logic [CFG_W-1:0] SEQ_EN_MASK = 8'h0A;

  typedef struct packed {
    logic rst;
    logic erase;
    logic altboot;
    logic pwr_down;
    logic pwr_up;
    logic pb_irq;
    logic tamper_irq;
  } req_t;

  function automatic logic last_step(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

  function automatic bit seq_enable_dropped(input logic [CFG_W-1:0] cur,
                                            input logic [CFG_W-1:0] nxt);
    return |(cur & ~nxt & SEQ_EN_MASK);
  endfunction
endpackage

// File: rtl/pbg_timer.sv
module pbg_timer #(
  parameter int HOLD_MS = 700,
  parameter int LONG_MS = 1000,
  parameter int GAP_MS  = 700,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          btn_i,
  input  logic          abort_i,
  output logic          hold_ev_o,
  output logic          long_ev_o,
  output logic          quick_rel_o,
  output logic          fin_o,
  output logic [CW-1:0] fin_cnt_o
);
  import pbg_pkg::*;
  localparam int MAXT = (LONG_MS > GAP_MS) ? LONG_MS : GAP_MS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          btn_q, long_q, seq_q;
  logic [TW-1:0] hold_cnt, gap_cnt;
  logic [CW-1:0] press_cnt;
  logic          held, idle, rise, fall;

  assign held = btn_i & btn_q;
  assign idle = ~btn_i & ~btn_q;
  assign rise = btn_i & ~btn_q;
  assign fall = ~btn_i & btn_q;

  assign hold_ev_o   = held & tick_i & last_step(hold_cnt, HOLD_MS);
  assign long_ev_o   = held & tick_i & last_step(hold_cnt, LONG_MS);
  assign quick_rel_o = fall & ~long_q;
  assign fin_o       = seq_q & idle & tick_i & ~abort_i & last_step(gap_cnt, GAP_MS);
  assign fin_cnt_o   = press_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q    <= 1'b0;
      long_q   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      btn_q <= btn_i;
      if (rise) begin
        hold_cnt <= '0;
        long_q   <= 1'b0;
      end else if (held && tick_i && hold_cnt != TW'(LONG_MS)) begin
        hold_cnt <= hold_cnt + 1'b1;
      end
      if (hold_ev_o) long_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      press_cnt <= '0;
      seq_q     <= 1'b0;
      gap_cnt   <= '0;
    end else if (abort_i || fin_o) begin
      press_cnt <= '0;
      seq_q     <= 1'b0;
      gap_cnt   <= '0;
    end else if (quick_rel_o) begin
      if (press_cnt != CNT_MAX) press_cnt <= press_cnt + 1'b1;
      seq_q   <= 1'b1;
      gap_cnt <= '0;
    end else if (rise || fall) begin
      gap_cnt <= '0;
    end else if (seq_q && idle && tick_i) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> (press_cnt == '0)) else $error("count kept after finish"); // R2
  AST_LONG_NOT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && long_q && !abort_i && !fin_o) |=> $stable(press_cnt)) else $error("long press counted"); // R9
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (press_cnt == '0)) else $error("abort ignored"); // R10
endmodule

// File: rtl/pbg_decode.sv
module pbg_decode #(
  parameter int CW = 3
) (
  input  logic [pbg_pkg::CFG_W-1:0] cfg_i,
  input  logic                      down_i,
  input  logic                      quick_rel_i,
  input  logic                      hold_ev_i,
  input  logic                      long_ev_i,
  input  logic                      fin_i,
  input  logic [CW-1:0]             fin_cnt_i,
  input  logic                      tamper_rel_i,
  output pbg_pkg::req_t             req_o
);
  import pbg_pkg::*;

  always_comb begin
    req_o = '0;
    if (down_i) begin
      req_o.pwr_up = quick_rel_i;
    end else begin
      if (fin_i) begin
        if (fin_cnt_i >= CW'(5)) begin
          req_o.altboot = cfg_i[B_ALTBOOT];
        end else if (fin_cnt_i == CW'(3)) begin
          req_o.erase  = cfg_i[B_CLRKEY];
          req_o.pb_irq = cfg_i[B_CLRKEY];
        end else if (fin_cnt_i == CW'(1)) begin
          req_o.rst    = cfg_i[B_SHORT_RST];
          req_o.pb_irq = ~cfg_i[B_SHORT_RST];
        end
      end
      if (hold_ev_i && cfg_i[B_HOLD]) req_o.pb_irq = 1'b1;
      if (long_ev_i && cfg_i[B_PWRDN]) begin
        req_o.pwr_down = 1'b1;
        req_o.pb_irq   = 1'b1;
      end
    end
    if (tamper_rel_i && cfg_i[B_TAMPER]) begin
      req_o.erase      = 1'b1;
      req_o.tamper_irq = 1'b1;
    end
  end
endmodule

// File: rtl/pb_gesture_ctrl.sv
module pb_gesture_ctrl #(
  parameter int HOLD_MS = 700,
  parameter int LONG_MS = 1000,
  parameter int GAP_MS  = 700,
  parameter int CW      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       btn_i,
  input  logic       tamper_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_o,
  output logic       rst_req_o,
  output logic       erase_req_o,
  output logic       altboot_req_o,
  output logic       pwr_down_o,
  output logic       pwr_up_o,
  output logic       pb_irq_o,
  output logic       tamper_irq_o
);
  import pbg_pkg::*;

  logic [CFG_W-1:0] cfg_q;
  logic             down_q, tamper_q;
  logic             hold_ev, long_ev, quick_rel, fin, tamper_rel, abort;
  logic [CW-1:0]    fin_cnt;
  req_t             req, req_q;

  assign tamper_rel = tamper_q & ~tamper_i;
  assign abort = (cfg_we_i && seq_enable_dropped(cfg_q, cfg_wdata_i)) || down_q;

  pbg_timer #(.HOLD_MS(HOLD_MS), .LONG_MS(LONG_MS), .GAP_MS(GAP_MS), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .btn_i(btn_i), .abort_i(abort),
    .hold_ev_o(hold_ev), .long_ev_o(long_ev), .quick_rel_o(quick_rel),
    .fin_o(fin), .fin_cnt_o(fin_cnt));

  pbg_decode #(.CW(CW)) u_decode (
    .cfg_i(cfg_q), .down_i(down_q), .quick_rel_i(quick_rel), .hold_ev_i(hold_ev),
    .long_ev_i(long_ev), .fin_i(fin), .fin_cnt_i(fin_cnt), .tamper_rel_i(tamper_rel),
    .req_o(req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RESET;
      down_q   <= 1'b0;
      tamper_q <= 1'b0;
      req_q    <= '0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_wdata_i;
      tamper_q <= tamper_i;
      req_q    <= req;
      if (req.pwr_down)    down_q <= 1'b1;
      else if (req.pwr_up) down_q <= 1'b0;
    end
  end

  assign cfg_o         = cfg_q;
  assign rst_req_o     = req_q.rst;
  assign erase_req_o   = req_q.erase;
  assign altboot_req_o = req_q.altboot;
  assign pwr_down_o    = req_q.pwr_down;
  assign pwr_up_o      = req_q.pwr_up;
  assign pb_irq_o      = req_q.pb_irq;
  assign tamper_irq_o  = req_q.tamper_irq;

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o) else $error("reset pulse too long"); // R12
  AST_ALTBOOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    altboot_req_o |=> !altboot_req_o) else $error("altboot pulse too long"); // R12
  AST_ALTBOOT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    altboot_req_o |-> !rst_req_o && !pb_irq_o) else $error("altboot mixed"); // R4
  AST_ALTBOOT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    altboot_req_o |-> $past(cfg_q[B_ALTBOOT])) else $error("altboot disabled"); // R4
  AST_PWRDN_EN: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_o |-> $past(cfg_q[B_PWRDN]) && down_q) else $error("power-down wrong"); // R6
  AST_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(down_q) |-> !rst_req_o && !altboot_req_o) else $error("action while down"); // R7
  AST_PWRUP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up_o |-> !down_q) else $error("still down after power-up"); // R7
  AST_TAMPER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    tamper_irq_o |-> erase_req_o && $past(cfg_q[B_TAMPER])) else $error("tamper irq alone"); // R8
endmodule

// File: tb/tb_pb_gesture_ctrl.sv
module tb_pb_gesture_ctrl;
  localparam int HOLD = 70;
  localparam int LONG = 100;
  localparam int GAP  = 70;

  logic clk = 0, rst_n = 0, tick = 0, btn = 0, tamper = 0, we = 0;
  logic [7:0] wdata = 0, cfg;
  logic rst_r, erase_r, alt_r, pdn_r, pup_r, irq_r, tirq_r;
  int checks = 0, errors = 0, cyc = 0;
  int c_rst, c_erase, c_alt, c_pdn, c_pup, c_irq, c_tirq, wide;
  logic [6:0] prev;

  always #10 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  pb_gesture_ctrl #(.HOLD_MS(HOLD), .LONG_MS(LONG), .GAP_MS(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .btn_i(btn), .tamper_i(tamper),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_o(cfg), .rst_req_o(rst_r),
    .erase_req_o(erase_r), .altboot_req_o(alt_r), .pwr_down_o(pdn_r),
    .pwr_up_o(pup_r), .pb_irq_o(irq_r), .tamper_irq_o(tirq_r));

  always @(negedge clk) begin
    logic [6:0] cur;
    cur = {rst_r, erase_r, alt_r, pdn_r, pup_r, irq_r, tirq_r};
    if (rst_n) begin
      c_rst += int'(rst_r); c_erase += int'(erase_r); c_alt += int'(alt_r);
      c_pdn += int'(pdn_r); c_pup += int'(pup_r); c_irq += int'(irq_r);
      c_tirq += int'(tirq_r);
      if ((cur & prev) != 0) wide++;
    end
    prev = cur;
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clr();
    c_rst = 0; c_erase = 0; c_alt = 0; c_pdn = 0; c_pup = 0; c_irq = 0; c_tirq = 0;
  endtask

  task automatic ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); we = 1; wdata = v;
    @(negedge clk); we = 0;
  endtask

  task automatic press(input int h, input int g);
    @(negedge clk); btn = 1; ticks(h);
    @(negedge clk); btn = 0; ticks(g);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) press(2 + $urandom_range(0, 40), 2 + $urandom_range(0, 40));
  endtask

  function automatic int e_rst(input logic [7:0] c, input int n);
    return (n == 1 && c[0]) ? 1 : 0;
  endfunction
  function automatic int e_erase(input logic [7:0] c, input int n);
    return (n == 3 && c[1]) ? 1 : 0;
  endfunction
  function automatic int e_alt(input logic [7:0] c, input int n);
    return (n >= 5 && c[3]) ? 1 : 0;
  endfunction
  function automatic int e_irq(input logic [7:0] c, input int n);
    if (n == 1) return c[0] ? 0 : 1;
    if (n == 3) return c[1] ? 1 : 0;
    return 0;
  endfunction

  initial begin
    int unused_seed;
    unused_seed = $urandom(1234);
    clr(); wide = 0; prev = '0;
    repeat (3) @(negedge clk);
    chk("R1 cfg reset", int'(cfg), 'h81);
    chk("R1 outputs idle", int'({rst_r, erase_r, alt_r, pdn_r, pup_r, irq_r, tirq_r}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2: single press with default config resets
    clr(); press(10, GAP + 20);
    chk("R2 single rst", c_rst, 1); chk("R2 single no irq", c_irq, 0);

    // R2/R11: bit0 clear, bit7 set -> interrupt only
    wr(8'h80); clr(); press(10, GAP + 20);
    chk("R2 single irq", c_irq, 1); chk("R11 bit7 no reset", c_rst, 0);

    // R3: triple
    wr(8'h03); clr(); run(3); ticks(GAP + 20);
    chk("R3 erase", c_erase, 1); chk("R3 irq", c_irq, 1); chk("R3 no rst", c_rst, 0);

    // R4: five presses, alt boot only
    wr(8'h0B); clr(); run(5); ticks(GAP + 20);
    chk("R4 altboot", c_alt, 1); chk("R4 no erase", c_erase, 0);
    chk("R4 no rst", c_rst, 0); chk("R4 no irq", c_irq, 0);

    // R4: two presses do nothing
    clr(); run(2); ticks(GAP + 20);
    chk("R4 two nothing", c_rst + c_erase + c_alt + c_irq, 0);

    // R5/R9: hold past first threshold, then short press; the held one not counted
    wr(8'h41); clr(); press(10, 20); press(HOLD + 15, GAP + 20);
    chk("R5 hold irq", c_irq, 1); chk("R9 long not counted", c_rst, 1);

    // R5: bit6 clear -> hold silent
    wr(8'h01); clr(); press(HOLD + 15, GAP + 20);
    chk("R5 hold silent", c_irq + c_rst, 0);

    // R6/R7: power down then power up
    wr(8'h05); clr(); press(LONG + 20, GAP + 20);
    chk("R6 pwr down", c_pdn, 1); chk("R6 irq", c_irq, 1); chk("R6 no rst", c_rst, 0);
    clr(); press(10, GAP + 20);
    chk("R7 pwr up", c_pup, 1); chk("R7 no rst", c_rst, 0); chk("R7 no irq", c_irq, 0);
    clr(); press(10, GAP + 20);
    chk("R7 left down state", c_rst, 1);

    // R8: tamper enabled and disabled
    wr(8'h20); clr(); @(negedge clk); tamper = 1; ticks(5); tamper = 0; ticks(5);
    chk("R8 tamper erase", c_erase, 1); chk("R8 tamper irq", c_tirq, 1);
    wr(8'h00); clr(); tamper = 1; ticks(5); tamper = 0; ticks(5);
    chk("R8 tamper ignored", c_erase + c_tirq, 0);

    // R10: two presses, drop bit1 -> count restarts, next single press resets
    wr(8'h03); clr(); run(2); wr(8'h01); press(10, GAP + 20);
    chk("R10 abort restart", c_rst, 1); chk("R10 no erase", c_erase, 0);

    // random runs against the bench model (bit2 kept clear)
    for (int it = 0; it < 25; it++) begin
      logic [7:0] c;
      int n;
      c = 8'($urandom) & 8'hFB;
      n = 1 + $urandom_range(0, 5);
      wr(c); clr(); run(n); ticks(GAP + 20);
      chk("R2 rand rst", c_rst, e_rst(c, n));
      chk("R3 rand erase", c_erase, e_erase(c, n));
      chk("R4 rand alt", c_alt, e_alt(c, n));
      chk("R11 rand irq", c_irq, e_irq(c, n));
    end

    chk("R12 single-cycle pulses", wide, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule